// File: doc/BRIEF.md
# Column-Reuse Sliding Window Buffer

This block feeds a window-based image filter from an external memory that holds a raster image packed several pixels to a word. It keeps a window of 11 image rows by 15 pixels in three on-chip word sections. Each section holds one vertical strip of 11 packed words, 5 pixels wide. For each step it fetches only one new strip of 11 words from external memory and writes it over the oldest section. It then shows the whole window, left to right, so that a downstream filter can form five 11x11 neighbourhoods. After that the window has moved five pixels to the right.

The column index only increments. When a row ends, the next fetch takes the following words of the raster, so the window moves down one pixel row with no special case. Each image row is padded to 515 pixels, or 103 words, and this makes the row a whole number of words. A neighbourhood that straddles two image rows is still produced, and a per-result flag marks it as unusable. The external side is a word-address request port with ready, plus an in-order response stream of any latency. The internal side is a one-cycle window strobe.

Top module: `colreuse_window`

## Requirements
- R1: While reset is asserted, and afterwards until `run` is first sampled high, `req_valid` and `win_valid` are low.
- R2: Row r (0 to 10) of column c is requested at word address c + r*103. The rows of a column are requested in ascending order. The column index starts at 0 after reset and rises by exactly one per step, including across row ends.
- R3: A new column fetch starts only if `run` is high while the block is idle. A fetch that has started runs to completion. A request stays asserted with an unchanged address until it is accepted (`req_valid` and `req_ready` both high at a clock edge).
- R4: The first request of a column is issued only when no response is outstanding.
- R5: `win_valid` stays low until the responses for three complete columns (33 words) have been taken. It rises first in the cycle after the 33rd response.
- R6: During `win_valid`, window pixel (row r, column x) sits at `win_pix[(r*15+x)*12 +: 12]`. It equals pixel x mod 5 of the word at address (n + x/5) + r*103, where n is the newest column index minus 2. Pixel k of a word is in bits [k*12 +: 12]. Word bits 63:60 are ignored.
- R7: After the fill, `win_valid` is a single-cycle pulse in the cycle after the last response of each column. It is never high in two consecutive cycles.
- R8: `win_bad[k]` (k = 0..4) is 1 exactly when the 11-pixel span of result k crosses an image row. The span starts at window column k. The condition is ((n mod 103)*5 + k + 10) >= 515.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| run | input | 1 | Permits the start of a new column fetch |
| req_valid | output | 1 | Word read request present |
| req_ready | input | 1 | Memory side accepts the request this cycle |
| req_addr | output | 20 | Word address of the request |
| rsp_valid | input | 1 | Returned word present, in request order |
| rsp_data | input | 64 | Returned packed word |
| win_valid | output | 1 | Window contents and flags are valid this cycle |
| win_pix | output | 1980 | 11 x 15 window of 12-bit pixels, row-major |
| win_bad | output | 5 | Row-straddle flag per result |

## Verification
Suppose the section pointer goes wrong. Then the strip order in the window no longer matches its address, and the first window after the fault has pixels in the wrong columns. A slip in the row or column counters shows first at the request port, in the next address issued. A wrong fill count or a lost response moves or removes the first strobe, which belongs one cycle after the 33rd word. A wrong row-position counter gives wrong straddle flags, and this is seen when the window reaches the next row end. That point comes at most 103 steps later.

// File: rtl/cr_window_pkg.sv
package cr_window_pkg;

   typedef enum logic [1:0] {
      FS_IDLE  = 2'd0,
      FS_ISSUE = 2'd1,
      FS_DRAIN = 2'd2
   } fetch_state_t;

endpackage

// File: rtl/cr_fetch_seq.sv
module cr_fetch_seq
   import cr_window_pkg::*;
#(
   parameter int ADDR_W    = 20,
   parameter int ROWS      = 11,
   parameter int ROW_WORDS = 103
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         run,
   input  logic                         req_ready,
   input  logic                         rsp_valid,
   output logic                         req_valid,
   output logic [ADDR_W-1:0]            req_addr,
   output logic [$clog2(ROWS)-1:0]      rsp_row,
   output logic                         col_done,
   output logic [$clog2(ROW_WORDS)-1:0] col_mod
);

   localparam int RW    = $clog2(ROWS);
   localparam int MOD_W = $clog2(ROW_WORDS);
   localparam logic [RW-1:0]     LAST_ROW  = RW'(ROWS - 1);
   localparam logic [MOD_W-1:0]  LAST_MOD  = MOD_W'(ROW_WORDS - 1);
   localparam logic [ADDR_W-1:0] ROW_STEP  = ADDR_W'(ROW_WORDS);

   fetch_state_t      state_q;
   logic [ADDR_W-1:0] col_q;
   logic [ADDR_W-1:0] addr_q;
   logic [RW-1:0]     issue_q;
   logic [RW-1:0]     ret_q;
   logic [MOD_W-1:0]  mod_q;

   always_comb begin
      req_valid = (state_q == FS_ISSUE);
      req_addr  = addr_q;
      rsp_row   = ret_q;
      col_done  = rsp_valid && (ret_q == LAST_ROW);
      col_mod   = mod_q;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= FS_IDLE;
         col_q   <= '0;
         addr_q  <= '0;
         issue_q <= '0;
         ret_q   <= '0;
         mod_q   <= '0;
      end else begin
         unique case (state_q)
            FS_IDLE: begin
               if (run) begin
                  state_q <= FS_ISSUE;
                  addr_q  <= col_q;
                  issue_q <= '0;
               end
            end
            FS_ISSUE: begin
               if (req_ready) begin
                  addr_q <= addr_q + ROW_STEP;
                  if (issue_q == LAST_ROW) begin
                     state_q <= FS_DRAIN;
                  end else begin
                     issue_q <= issue_q + RW'(1);
                  end
               end
            end
            FS_DRAIN: begin
               if (col_done) begin
                  state_q <= FS_IDLE;
                  col_q   <= col_q + ADDR_W'(1);
                  mod_q   <= (mod_q == LAST_MOD) ? '0 : mod_q + MOD_W'(1);
               end
            end
            default: state_q <= FS_IDLE;
         endcase
         if (rsp_valid) begin
            ret_q <= (ret_q == LAST_ROW) ? '0 : ret_q + RW'(1);
         end
      end
   end

endmodule

// File: rtl/cr_section_store.sv
module cr_section_store #(
   parameter int WORD_W = 64,
   parameter int ROWS   = 11,
   parameter int SECTS  = 3
) (
   input  logic                            clk,
   input  logic                            rst_n,
   input  logic                            wr_en,
   input  logic [$clog2(ROWS)-1:0]         wr_row,
   input  logic [WORD_W-1:0]               wr_data,
   input  logic                            advance,
   output logic [$clog2(SECTS)-1:0]        oldest,
   output logic [$clog2(SECTS+1)-1:0]      fill_cnt,
   output logic [SECTS*ROWS*WORD_W-1:0]    sec_data
);

   localparam int RW = $clog2(ROWS);
   localparam int PW = $clog2(SECTS);
   localparam int FW = $clog2(SECTS + 1);
   localparam logic [PW-1:0] LAST_SEC = PW'(SECTS - 1);
   localparam logic [FW-1:0] FULL     = FW'(SECTS);

   logic [PW-1:0] ptr_q;
   logic [FW-1:0] fill_q;

   for (genvar s = 0; s < SECTS; s++) begin : g_sect
      for (genvar r = 0; r < ROWS; r++) begin : g_row
         logic [WORD_W-1:0] cell_q;
         always_ff @(posedge clk) begin
            if (wr_en && (ptr_q == PW'(s)) && (wr_row == RW'(r))) begin
               cell_q <= wr_data;
            end
         end
         assign sec_data[(s*ROWS + r)*WORD_W +: WORD_W] = cell_q;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ptr_q  <= '0;
         fill_q <= '0;
      end else if (advance) begin
         ptr_q <= (ptr_q == LAST_SEC) ? '0 : ptr_q + PW'(1);
         if (fill_q != FULL) begin
            fill_q <= fill_q + FW'(1);
         end
      end
   end

   assign oldest   = ptr_q;
   assign fill_cnt = fill_q;

endmodule

// File: rtl/cr_window_view.sv
module cr_window_view #(
   parameter int WORD_W       = 64,
   parameter int PIX_W        = 12,
   parameter int PIX_PER_WORD = 5,
   parameter int ROWS         = 11,
   parameter int SECTS        = 3,
   parameter int ROW_WORDS    = 103
) (
   input  logic [SECTS*ROWS*WORD_W-1:0]                   sec_data,
   input  logic [$clog2(SECTS)-1:0]                       oldest,
   input  logic [$clog2(ROW_WORDS)-1:0]                   left_mod,
   output logic [ROWS*SECTS*PIX_PER_WORD*PIX_W-1:0]       win_pix,
   output logic [SECTS*PIX_PER_WORD-ROWS:0]               win_bad
);

   localparam int PW       = $clog2(SECTS);
   localparam int WIN_COLS = SECTS * PIX_PER_WORD;
   localparam int RES_N    = WIN_COLS - ROWS + 1;
   localparam int ROW_PIX  = ROW_WORDS * PIX_PER_WORD;

   for (genvar w = 0; w < SECTS; w++) begin : g_pos
      logic [PW:0]   sum;
      logic [PW-1:0] sel;
      assign sum = {1'b0, oldest} + (PW+1)'(w);
      assign sel = (sum >= (PW+1)'(SECTS)) ? PW'(sum - (PW+1)'(SECTS)) : PW'(sum);
      for (genvar r = 0; r < ROWS; r++) begin : g_row
         logic [WORD_W-1:0] word;
         always_comb begin
            word = '0;
            for (int s = 0; s < SECTS; s++) begin
               if (sel == PW'(s)) begin
                  word = sec_data[(s*ROWS + r)*WORD_W +: WORD_W];
               end
            end
         end
         for (genvar k = 0; k < PIX_PER_WORD; k++) begin : g_pix
            assign win_pix[(r*WIN_COLS + w*PIX_PER_WORD + k)*PIX_W +: PIX_W] =
               word[k*PIX_W +: PIX_W];
         end
      end
   end

   for (genvar k = 0; k < RES_N; k++) begin : g_flag
      assign win_bad[k] = ((32'(left_mod) * PIX_PER_WORD + k + ROWS - 1) >= ROW_PIX);
   end

endmodule

// File: rtl/colreuse_window.sv
module colreuse_window #(
   parameter int ADDR_W       = 20,
   parameter int WORD_W       = 64,
   parameter int PIX_W        = 12,
   parameter int PIX_PER_WORD = 5,
   parameter int ROWS         = 11,
   parameter int SECTS        = 3,
   parameter int ROW_WORDS    = 103
) (
   input  logic                                     clk,
   input  logic                                     rst_n,
   input  logic                                     run,
   output logic                                     req_valid,
   input  logic                                     req_ready,
   output logic [ADDR_W-1:0]                        req_addr,
   input  logic                                     rsp_valid,
   input  logic [WORD_W-1:0]                        rsp_data,
   output logic                                     win_valid,
   output logic [ROWS*SECTS*PIX_PER_WORD*PIX_W-1:0] win_pix,
   output logic [SECTS*PIX_PER_WORD-ROWS:0]         win_bad
);

   localparam int RW    = $clog2(ROWS);
   localparam int PW    = $clog2(SECTS);
   localparam int FW    = $clog2(SECTS + 1);
   localparam int MOD_W = $clog2(ROW_WORDS);
   localparam logic [MOD_W-1:0] BACK = MOD_W'(SECTS - 1);

   if (PIX_PER_WORD * PIX_W > WORD_W) begin : g_bad_pack
      $error("packed pixels exceed the word width");
   end
   if (SECTS * PIX_PER_WORD < ROWS) begin : g_bad_span
      $error("window narrower than one neighbourhood");
   end
   if (SECTS < 2 || ROW_WORDS < SECTS || ROWS < 2) begin : g_bad_geom
      $error("window geometry out of range");
   end

   logic [RW-1:0]    rsp_row;
   logic             col_done;
   logic [MOD_W-1:0] col_mod;
   logic [PW-1:0]    oldest;
   logic [FW-1:0]    fill_cnt;
   logic [SECTS*ROWS*WORD_W-1:0] sec_data;
   logic [MOD_W-1:0] left_mod_q;
   logic             win_valid_q;

   cr_fetch_seq #(
      .ADDR_W    (ADDR_W),
      .ROWS      (ROWS),
      .ROW_WORDS (ROW_WORDS)
   ) u_fetch (
      .clk       (clk),
      .rst_n     (rst_n),
      .run       (run),
      .req_ready (req_ready),
      .rsp_valid (rsp_valid),
      .req_valid (req_valid),
      .req_addr  (req_addr),
      .rsp_row   (rsp_row),
      .col_done  (col_done),
      .col_mod   (col_mod)
   );

   cr_section_store #(
      .WORD_W (WORD_W),
      .ROWS   (ROWS),
      .SECTS  (SECTS)
   ) u_store (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (rsp_valid),
      .wr_row   (rsp_row),
      .wr_data  (rsp_data),
      .advance  (col_done),
      .oldest   (oldest),
      .fill_cnt (fill_cnt),
      .sec_data (sec_data)
   );

   cr_window_view #(
      .WORD_W       (WORD_W),
      .PIX_W        (PIX_W),
      .PIX_PER_WORD (PIX_PER_WORD),
      .ROWS         (ROWS),
      .SECTS        (SECTS),
      .ROW_WORDS    (ROW_WORDS)
   ) u_view (
      .sec_data (sec_data),
      .oldest   (oldest),
      .left_mod (left_mod_q),
      .win_pix  (win_pix),
      .win_bad  (win_bad)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         win_valid_q <= 1'b0;
         left_mod_q  <= '0;
      end else begin
         win_valid_q <= col_done && (fill_cnt >= FW'(SECTS - 1));
         if (col_done) begin
            left_mod_q <= (col_mod >= BACK) ? col_mod - BACK
                                            : col_mod + MOD_W'(ROW_WORDS) - BACK;
         end
      end
   end

   assign win_valid = win_valid_q;

endmodule

// File: rtl/cr_window_chk.sv
module cr_window_chk #(
   parameter int ADDR_W    = 20,
   parameter int ROWS      = 11,
   parameter int ROW_WORDS = 103,
   parameter int SECTS     = 3
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_valid,
   input logic              req_ready,
   input logic [ADDR_W-1:0] req_addr,
   input logic              rsp_valid,
   input logic              win_valid
);

   localparam int RW   = $clog2(ROWS);
   localparam int OW   = $clog2(ROWS + 1) + 1;
   localparam int FILL = ROWS * SECTS;
   localparam int TW   = $clog2(FILL + 1);

   logic [RW-1:0]     row_c;
   logic [ADDR_W-1:0] col_c;
   logic [ADDR_W-1:0] exp_addr;
   logic [OW-1:0]     out_c;
   logic [TW-1:0]     rsp_tot;
   logic              acc;

   assign acc = req_valid && req_ready;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         row_c    <= '0;
         col_c    <= '0;
         exp_addr <= '0;
         out_c    <= '0;
         rsp_tot  <= '0;
      end else begin
         if (acc) begin
            if (row_c == RW'(ROWS - 1)) begin
               row_c    <= '0;
               col_c    <= col_c + ADDR_W'(1);
               exp_addr <= col_c + ADDR_W'(1);
            end else begin
               row_c    <= row_c + RW'(1);
               exp_addr <= exp_addr + ADDR_W'(ROW_WORDS);
            end
         end
         out_c <= out_c + OW'(acc) - OW'(rsp_valid);
         if (rsp_valid && rsp_tot != TW'(FILL)) begin
            rsp_tot <= rsp_tot + TW'(1);
         end
      end
   end

   // R3
   req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && !req_ready |=> req_valid && $stable(req_addr));

   // R2
   addr_seq_chk: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |-> req_addr == exp_addr);

   // R4
   col_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && row_c == '0 |-> out_c == '0);

   // R5
   fill_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      win_valid |-> rsp_tot == TW'(FILL));

   // R7
   single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      win_valid |=> !win_valid);

   // R7
   win_settled_chk: assert property (@(posedge clk) disable iff (!rst_n)
      win_valid |-> out_c == '0 && !req_valid);

endmodule

bind colreuse_window cr_window_chk #(
   .ADDR_W    (ADDR_W),
   .ROWS      (ROWS),
   .ROW_WORDS (ROW_WORDS),
   .SECTS     (SECTS)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .req_valid (req_valid),
   .req_ready (req_ready),
   .req_addr  (req_addr),
   .rsp_valid (rsp_valid),
   .win_valid (win_valid)
);

// File: tb/colreuse_window_bench.sv
module colreuse_window_bench;

   localparam int AW   = 20;
   localparam int WW   = 64;
   localparam int PXW  = 12;
   localparam int NR   = 11;
   localparam int NCOL = 15;
   localparam int RWD  = 103;
   localparam int LAT  = 3;
   localparam int NTAB = 10;

   // {newest column index, expected win_bad}
   localparam logic [15:0] TBL [NTAB] = '{
      {11'd2,   5'h00}, {11'd3,   5'h00}, {11'd102, 5'h00}, {11'd103, 5'h1F},
      {11'd104, 5'h1F}, {11'd105, 5'h00}, {11'd205, 5'h00}, {11'd206, 5'h1F},
      {11'd207, 5'h1F}, {11'd208, 5'h00}
   };

   logic clk = 1'b0;
   logic rst_n;
   logic run;
   logic req_valid;
   logic req_ready;
   logic [AW-1:0] req_addr;
   logic rsp_valid;
   logic [WW-1:0] rsp_data;
   logic win_valid;
   logic [NR*NCOL*PXW-1:0] win_pix;
   logic [4:0] win_bad;

   int checks = 0;
   int errors = 0;
   int cyc = 0;
   int acc_n = 0;
   int rsp_n = 0;
   int out_cnt = 0;
   int win_n = 0;
   int req_seen = 0;
   int first_rsp = -1;
   int dbl = 0;
   bit exp_win = 1'b0;
   bit prev_win = 1'b0;
   bit done = 1'b0;
   logic [4:0] seen_bad [256];
   bit pv [LAT];
   logic [AW-1:0] pa [LAT];

   always #5 clk = ~clk;

   colreuse_window u_colreuse_window (
      .clk       (clk),
      .rst_n     (rst_n),
      .run       (run),
      .req_valid (req_valid),
      .req_ready (req_ready),
      .req_addr  (req_addr),
      .rsp_valid (rsp_valid),
      .rsp_data  (rsp_data),
      .win_valid (win_valid),
      .win_pix   (win_pix),
      .win_bad   (win_bad)
   );

   function automatic logic [WW-1:0] mem_word(input int a);
      logic [WW-1:0] w;
      w = '0;
      for (int k = 0; k < 5; k++) w[k*PXW +: PXW] = 12'((a*5 + k)*37 + 11);
      w[63:60] = 4'(a) ^ 4'hA;
      return w;
   endfunction

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // memory model and monitor, all at the falling edge
   initial begin
      for (int i = 0; i < LAT; i++) begin pv[i] = 1'b0; pa[i] = '0; end
      req_ready = 1'b0;
      rsp_valid = 1'b0;
      rsp_data  = '0;
      forever begin
         @(negedge clk);
         cyc++;
         if (rst_n === 1'b1) begin
            // R5 R7 strobe timing
            if (win_valid || exp_win)
               check(win_valid == exp_win, "R7 strobe timing", int'(win_valid), int'(exp_win));
            if (win_valid && prev_win) dbl++;
            prev_win = win_valid;
            if (win_valid) begin
               int left;
               int bad_pix;
               logic [4:0] eb;
               left = win_n;
               if (first_rsp < 0) first_rsp = rsp_n;
               bad_pix = 0;
               for (int r = 0; r < NR; r++) begin
                  for (int c = 0; c < NCOL; c++) begin
                     logic [WW-1:0] w;
                     w = mem_word(left + c/5 + r*RWD);
                     if (win_pix[(r*NCOL + c)*PXW +: PXW] !== w[(c%5)*PXW +: PXW]) bad_pix++;
                  end
               end
               // R6 every window pixel
               check(bad_pix == 0, "R6 window pixels", bad_pix, 0);
               for (int k = 0; k < 5; k++) eb[k] = (((left % RWD)*5 + k + 10) >= 515);
               // R8 straddle flags
               check(win_bad == eb, "R8 straddle flags", int'(win_bad), int'(eb));
               if (win_n < 256) seen_bad[win_n] = win_bad;
               win_n++;
            end
         end
         exp_win = 1'b0;
         if (req_valid) req_seen++;
         req_ready = (cyc % 3) != 1;
         if (req_valid && req_ready) begin
            int row;
            int col;
            row = acc_n % NR;
            col = acc_n / NR;
            // R2 address sequence
            check(req_addr == AW'(col + row*RWD), "R2 request address", int'(req_addr), col + row*RWD);
            // R4 no response outstanding at column start
            if (row == 0) check(out_cnt == 0, "R4 outstanding at column start", out_cnt, 0);
         end
         rsp_valid = pv[LAT-1];
         rsp_data  = pv[LAT-1] ? mem_word(int'(pa[LAT-1])) : {WW{1'b1}};
         if (pv[LAT-1]) begin
            out_cnt--;
            rsp_n++;
            if (rsp_n % NR == 0 && rsp_n >= 3*NR) exp_win = 1'b1;
         end
         for (int i = LAT-1; i > 0; i--) begin pv[i] = pv[i-1]; pa[i] = pa[i-1]; end
         pv[0] = req_valid && req_ready;
         pa[0] = req_addr;
         if (req_valid && req_ready) begin
            acc_n++;
            out_cnt++;
         end
      end
   end

   task automatic summary();
      $display("Result: errors=%0d of %0d checks", errors, checks);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         checks++;
         errors++;
         $display("FAIL watchdog expired actual=%0d expected=%0d", win_n, 210);
         summary();
         $finish;
      end
   end

   initial begin
      int held;
      rst_n = 1'b0;
      run   = 1'b0;
      repeat (4) @(negedge clk);
      // R1 outputs quiet in reset
      check(req_valid == 1'b0, "R1 req_valid in reset", int'(req_valid), 0);
      check(win_valid == 1'b0, "R1 win_valid in reset", int'(win_valid), 0);
      rst_n = 1'b1;
      repeat (10) @(negedge clk);
      // R1 no fetch before run
      check(req_seen == 0, "R1 idle before run", req_seen, 0);
      run = 1'b1;
      while (win_n < 1) @(negedge clk);
      // R5 first window after 33 words
      check(first_rsp == 33, "R5 words before first window", first_rsp, 33);
      while (win_n < 60) @(negedge clk);
      run = 1'b0;
      repeat (60) @(negedge clk);
      held = req_seen;
      repeat (30) @(negedge clk);
      // R3 no column starts while run is low
      check(req_seen == held, "R3 run low holds fetch", req_seen - held, 0);
      run = 1'b1;
      while (win_n < 210) @(negedge clk);
      // R8 table of row-end flag values
      for (int i = 0; i < NTAB; i++) begin
         int n;
         n = int'(TBL[i][15:5]) - 2;
         check(seen_bad[n] == TBL[i][4:0], "R8 table flags", int'(seen_bad[n]), int'(TBL[i][4:0]));
      end
      // R7 never two adjacent strobes
      check(dbl == 0, "R7 adjacent strobes", dbl, 0);
      if (!done) begin
         done = 1'b1;
         summary();
         $finish;
      end
   end

endmodule